// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command and address pins of a DDR SDRAM controller from reset until the memory is ready for normal traffic. After reset it holds clock-enable low for a stabilization period, then raises it and steps through a fixed command script. The script is precharge-all, extended mode write, base mode write with DLL reset, a second precharge-all, a configurable number of auto refreshes, and a final base mode write with the DLL-reset bit cleared.

The minimum spacing after each command is set by a parameter, and every cycle between commands is a NOP. The block also waits for the DLL to lock, counted from the DLL-reset write. Only then does it raise `init_done`, which stays high until the next reset. Burst length, burst ordering, CAS latency and output drive strength come from static configuration inputs. These inputs are copied into the mode-register words.

Top module: `ddr_init_top`

## Requirements
- R1: While reset is high, and for exactly STAB_CYCLES clock edges after it falls, `ddr_cke` is low, the command is NOP and `init_done` is low. CKE first reads high after edge STAB_CYCLES.
- R2: The first command after reset appears one cycle after CKE rises. The cycle in which CKE rises carries a NOP.
- R3: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP=0111, precharge=0010, auto refresh=0001, mode write=0000. The non-NOP commands come in exactly this order: precharge, mode write, mode write, precharge, NUM_REFRESH auto refreshes, mode write.
- R4: Each precharge is a precharge-all: A10=1, all other address bits 0, BA=00.
- R5: The first mode write selects the extended register with BA=01. A0=0 enables the DLL, A1 equals `cfg_half_drive`, and all other address bits are 0.
- R6: The second and last mode writes use BA=00. They carry A[2:0]=`cfg_burst_len`, A3=`cfg_interleave`, A[6:4]=`cfg_cas_lat` and all other bits 0, except A8, which is 1 in the second write (DLL reset) and 0 in the last.
- R7: The distance from a command to the next one is exactly TRP_CYC after a precharge, TMRD_CYC after a mode write, and TRFC_CYC after an auto refresh.
- R8: Every cycle that is not a sequenced command drives NOP with BA and address all zero.
- R9: `init_done` first reads high exactly max(DLL_LOCK_CYC, 2·TMRD_CYC+TRP_CYC+NUM_REFRESH·TRFC_CYC)+1 cycles after the DLL-reset mode write.
- R10: Once high, `init_done` stays high with CKE high and NOP on the bus until reset.
- R11: A reset in the middle of the sequence returns the outputs to the R1 state at once, and the sequence restarts from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst length code for A[2:0] |
| cfg_interleave | input | 1 | Burst ordering bit for A3 |
| cfg_cas_lat | input | 3 | CAS latency code for A[6:4] |
| cfg_half_drive | input | 1 | Reduced output drive select for extended A1 |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address (mode-register select) |
| ddr_addr | output | ADDR_W | Address / mode-register opcode |
| init_done | output | 1 | Sequence complete, DLL locked |

## Verification
The step register feeds the pins directly, so a wrong step or a skipped refresh shows up in the same cycle as a wrong or missing command code. The bench catches it by comparing the captured command list with the expected script. If the gap counter loads or ends one cycle off, the spacing between captured command cycles is off by one. If the DLL counter starts late or saturates early, `init_done` rises on the wrong cycle, and this is checked against the exact cycle R9 predicts. The checker also flags a non-NOP while CKE is low, a precharge without A10, and `init_done` falling before reset, each on the cycle it happens.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Command pin encoding, ordered {cs_n, ras_n, cas_n, we_n}.
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } ddr_cmd_e;

    // One state per script step; command steps last their gap length.
    typedef enum logic [3:0] {
        ST_STAB,
        ST_CKE,
        ST_PREA1,
        ST_EMRS,
        ST_MRS_RST,
        ST_PREA2,
        ST_AREF,
        ST_MRS_FIN,
        ST_LOCK,
        ST_DONE
    } init_step_e;

    typedef struct packed {
        logic [2:0] burst_len;
        logic       interleave;
        logic [2:0] cas_lat;
        logic       half_drive;
    } mode_cfg_t;

    localparam int PREA_BIT = 10;
    localparam int DLLRST_BIT = 8;

    // Base mode register opcode; unused bits stay zero.
    function automatic logic [15:0] base_mode_word(mode_cfg_t c, logic dll_rst);
        logic [15:0] w;
        w = '0;
        w[2:0] = c.burst_len;
        w[3] = c.interleave;
        w[6:4] = c.cas_lat;
        w[DLLRST_BIT] = dll_rst;
        return w;
    endfunction

    // Extended register opcode: DLL always enabled (bit 0 low).
    function automatic logic [15:0] ext_mode_word(mode_cfg_t c);
        logic [15:0] w;
        w = '0;
        w[0] = 1'b0;
        w[1] = c.half_drive;
        return w;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_gap_ctr.sv
module ddr_init_gap_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || restart)
            count <= '0;
        else if (count != '1)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int STAB_CYCLES  = 100,
    parameter int TRP_CYC      = 3,
    parameter int TMRD_CYC     = 2,
    parameter int TRFC_CYC     = 10,
    parameter int NUM_REFRESH  = 2,
    parameter int DLL_LOCK_CYC = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    output init_step_e       step,
    output logic             advance
);
    localparam int RW = (NUM_REFRESH > 1) ? $clog2(NUM_REFRESH) : 1;
    localparam logic [CNT_W-1:0] END_STAB = CNT_W'(STAB_CYCLES - 1);
    localparam logic [CNT_W-1:0] END_TRP  = CNT_W'(TRP_CYC - 1);
    localparam logic [CNT_W-1:0] END_MRD  = CNT_W'(TMRD_CYC - 1);
    localparam logic [CNT_W-1:0] END_RFC  = CNT_W'(TRFC_CYC - 1);
    localparam logic [CNT_W-1:0] DLL_END  = CNT_W'(DLL_LOCK_CYC);
    localparam logic [RW-1:0]    LAST_REF = RW'(NUM_REFRESH - 1);

    init_step_e       nxt;
    logic [RW-1:0]    ref_idx;
    logic [CNT_W-1:0] dll_cnt;

    always_comb begin
        advance = 1'b0;
        nxt     = step;
        unique case (step)
            ST_STAB:    begin advance = (cnt == END_STAB); nxt = ST_CKE;     end
            ST_CKE:     begin advance = 1'b1;              nxt = ST_PREA1;   end
            ST_PREA1:   begin advance = (cnt == END_TRP);  nxt = ST_EMRS;    end
            ST_EMRS:    begin advance = (cnt == END_MRD);  nxt = ST_MRS_RST; end
            ST_MRS_RST: begin advance = (cnt == END_MRD);  nxt = ST_PREA2;   end
            ST_PREA2:   begin advance = (cnt == END_TRP);  nxt = ST_AREF;    end
            ST_AREF: begin
                advance = (cnt == END_RFC);
                nxt     = (ref_idx == LAST_REF) ? ST_MRS_FIN : ST_AREF;
            end
            ST_MRS_FIN: begin advance = (cnt == END_MRD);  nxt = ST_LOCK;    end
            ST_LOCK:    begin advance = (dll_cnt == DLL_END); nxt = ST_DONE; end
            default:    begin advance = 1'b0;              nxt = ST_DONE;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= ST_STAB;
            ref_idx <= '0;
            dll_cnt <= '0;
        end else begin
            if (advance)
                step <= nxt;
            if (step == ST_AREF && advance)
                ref_idx <= ref_idx + 1'b1;
            // Cycles elapsed since the DLL-reset write, saturating at the lock time.
            if (step == ST_MRS_RST && cnt == '0)
                dll_cnt <= CNT_W'(1);
            else if (dll_cnt != '0 && dll_cnt != DLL_END)
                dll_cnt <= dll_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ddr_init_cmd_dec.sv
module ddr_init_cmd_dec
    import ddr_init_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 13
) (
    input  init_step_e        step,
    input  logic [CNT_W-1:0]  cnt,
    input  mode_cfg_t         cfg,
    output logic              cke,
    output ddr_cmd_e          cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    logic        first;
    logic [15:0] word;

    assign first = (cnt == '0);
    assign cke   = (step != ST_STAB);
    assign done  = (step == ST_DONE);

    always_comb begin
        cmd  = CMD_NOP;
        ba   = 2'b00;
        word = '0;
        if (first) begin
            unique case (step)
                ST_PREA1, ST_PREA2: begin
                    cmd = CMD_PRE;
                    word[PREA_BIT] = 1'b1;
                end
                ST_EMRS: begin
                    cmd  = CMD_MRS;
                    ba   = 2'b01;
                    word = ext_mode_word(cfg);
                end
                ST_MRS_RST: begin
                    cmd  = CMD_MRS;
                    word = base_mode_word(cfg, 1'b1);
                end
                ST_AREF:    cmd = CMD_AREF;
                ST_MRS_FIN: begin
                    cmd  = CMD_MRS;
                    word = base_mode_word(cfg, 1'b0);
                end
                default:    cmd = CMD_NOP;
            endcase
        end
    end

    assign addr = ADDR_W'(word);
endmodule

// File: rtl/ddr_init_top.sv
module ddr_init_top
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int STAB_CYCLES  = 100,
    parameter int TRP_CYC      = 3,
    parameter int TMRD_CYC     = 2,
    parameter int TRFC_CYC     = 10,
    parameter int NUM_REFRESH  = 2,
    parameter int DLL_LOCK_CYC = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_half_drive,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [1:0]        ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);
    localparam int LONGEST = max_of(max_of(STAB_CYCLES, DLL_LOCK_CYC),
                                    max_of(TRFC_CYC, max_of(TRP_CYC, TMRD_CYC)));
    localparam int CNT_W = $clog2(LONGEST + 2);

    mode_cfg_t        cfg;
    init_step_e       step;
    logic             advance;
    logic [CNT_W-1:0] cnt;
    ddr_cmd_e         cmd;

    assign cfg = '{burst_len: cfg_burst_len, interleave: cfg_interleave,
                   cas_lat: cfg_cas_lat, half_drive: cfg_half_drive};

    ddr_init_gap_ctr #(.CNT_W(CNT_W)) u_gap (
        .clk(clk), .rst(rst), .restart(advance), .count(cnt)
    );

    ddr_init_fsm #(
        .CNT_W(CNT_W), .STAB_CYCLES(STAB_CYCLES), .TRP_CYC(TRP_CYC),
        .TMRD_CYC(TMRD_CYC), .TRFC_CYC(TRFC_CYC), .NUM_REFRESH(NUM_REFRESH),
        .DLL_LOCK_CYC(DLL_LOCK_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .cnt(cnt), .step(step), .advance(advance)
    );

    ddr_init_cmd_dec #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dec (
        .step(step), .cnt(cnt), .cfg(cfg), .cke(ddr_cke), .cmd(cmd),
        .ba(ddr_ba), .addr(ddr_addr), .done(init_done)
    );

    assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd;
endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
    parameter int ADDR_W       = 13,
    parameter int TRP_CYC      = 3,
    parameter int TMRD_CYC     = 2,
    parameter int TRFC_CYC     = 10,
    parameter int DLL_LOCK_CYC = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              ddr_cke,
    input logic              ddr_cs_n,
    input logic              ddr_ras_n,
    input logic              ddr_cas_n,
    input logic              ddr_we_n,
    input logic [1:0]        ddr_ba,
    input logic [ADDR_W-1:0] ddr_addr,
    input logic              init_done
);
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic [3:0] pins;
    logic       is_cmd;
    logic [3:0] last_cmd;
    logic       seen;
    int         since;
    logic       dll_seen;
    int         dll_since;

    assign pins   = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
    assign is_cmd = (pins != C_NOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_cmd  <= C_NOP;
            seen      <= 1'b0;
            since     <= 0;
            dll_seen  <= 1'b0;
            dll_since <= 0;
        end else begin
            if (is_cmd) begin
                last_cmd <= pins;
                seen     <= 1'b1;
                since    <= 1;
            end else if (since < 1000000) begin
                since <= since + 1;
            end
            if (pins == C_MRS && ddr_ba == 2'b00 && ddr_addr[8]) begin
                dll_seen  <= 1'b1;
                dll_since <= 1;
            end else if (dll_seen && dll_since < 1000000) begin
                dll_since <= dll_since + 1;
            end
        end
    end

    a_r1_quiet_while_cke_low: assert property (@(posedge clk) disable iff (rst)
        !ddr_cke |-> (pins == C_NOP && !init_done));

    a_r2_cke_before_cmd: assert property (@(posedge clk) disable iff (rst)
        is_cmd |-> $past(ddr_cke));

    a_r4_prea_all: assert property (@(posedge clk) disable iff (rst)
        pins == C_PRE |-> (ddr_addr[10] && ddr_ba == 2'b00));

    a_r5_ext_fields: assert property (@(posedge clk) disable iff (rst)
        (pins == C_MRS && ddr_ba == 2'b01) |-> (!ddr_addr[0] && (ddr_addr >> 2) == '0));

    a_r7_gap_after_pre: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && seen && last_cmd == C_PRE) |-> since == TRP_CYC);

    a_r7_gap_after_mrs: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && seen && last_cmd == C_MRS) |-> since == TMRD_CYC);

    a_r7_gap_after_ref: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && seen && last_cmd == C_REF) |-> since == TRFC_CYC);

    a_r9_dll_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (dll_seen && dll_since >= DLL_LOCK_CYC + 1));

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (pins == C_NOP && ddr_cke));
endmodule

bind ddr_init_top ddr_init_chk #(
    .ADDR_W(ADDR_W), .TRP_CYC(TRP_CYC), .TMRD_CYC(TMRD_CYC),
    .TRFC_CYC(TRFC_CYC), .DLL_LOCK_CYC(DLL_LOCK_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
    .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
);

// File: tb/ddr_init_top_tb_top.sv
module ddr_init_top_tb_top;
    localparam int ADDR_W = 13;
    localparam int STAB   = 40;
    localparam int TRP    = 3;
    localparam int TMRD   = 2;
    localparam int TRFC   = 12;
    localparam int NREF   = 2;
    localparam int DLL    = 60;
    localparam int NEXP   = 7;
    localparam int SPAN   = 2 * TMRD + TRP + NREF * TRFC;

    // Expected script: command code, bank, distance to the next command.
    localparam logic [3:0] EXP_CMD [NEXP] = '{4'b0010, 4'b0000, 4'b0000, 4'b0010,
                                              4'b0001, 4'b0001, 4'b0000};
    localparam logic [1:0] EXP_BA  [NEXP] = '{2'b00, 2'b01, 2'b00, 2'b00,
                                              2'b00, 2'b00, 2'b00};
    localparam int         EXP_GAP [NEXP] = '{TRP, TMRD, TMRD, TRP, TRFC, TRFC, TMRD};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] bl = 3'b010;
    logic [2:0] cl = 3'b011;
    logic bt = 1'b0;
    logic hd = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0] ba;
    logic [ADDR_W-1:0] addr;

    int n_checks = 0;
    int n_err = 0;
    int cyc;

    logic [3:0]        cap_cmd  [16];
    logic [1:0]        cap_ba   [16];
    logic [ADDR_W-1:0] cap_addr [16];
    int                cap_cyc  [16];
    int cap_n, cke_cyc, done_cyc, nop_bad, sticky_bad;
    logic cke_seen, done_seen;

    always #10 clk = ~clk;   // 20-unit period, 50 MHz

    ddr_init_top #(
        .ADDR_W(ADDR_W), .STAB_CYCLES(STAB), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
        .TRFC_CYC(TRFC), .NUM_REFRESH(NREF), .DLL_LOCK_CYC(DLL)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_burst_len(bl), .cfg_interleave(bt),
        .cfg_cas_lat(cl), .cfg_half_drive(hd), .ddr_cke(cke), .ddr_cs_n(cs_n),
        .ddr_ras_n(ras_n), .ddr_cas_n(cas_n), .ddr_we_n(we_n), .ddr_ba(ba),
        .ddr_addr(addr), .init_done(done)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst) begin
            cap_n = 0; cke_seen = 1'b0; done_seen = 1'b0;
            cke_cyc = -1; done_cyc = -1; nop_bad = 0; sticky_bad = 0;
        end else begin
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (cap_n < 16) begin
                    cap_cmd[cap_n]  = {cs_n, ras_n, cas_n, we_n};
                    cap_ba[cap_n]   = ba;
                    cap_addr[cap_n] = addr;
                    cap_cyc[cap_n]  = cyc;
                end
                cap_n++;
            end else if (ba != 2'b00 || addr != '0) begin
                nop_bad++;
            end
            if (cke && !cke_seen) begin cke_seen = 1'b1; cke_cyc = cyc; end
            if (done && !done_seen) begin done_seen = 1'b1; done_cyc = cyc; end
            if (done_seen && (!done || !cke)) sticky_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int i);
        int mode;
        mode = (int'(cl) << 4) | (int'(bt) << 3) | int'(bl);
        case (i)
            0, 3:    return 1 << 10;
            1:       return int'(hd) << 1;
            2:       return (1 << 8) | mode;
            6:       return mode;
            default: return 0;
        endcase
    endfunction

    task automatic do_reset(input string tag);
        @(posedge clk); #2 rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!cke && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && !done, tag,
            {cke, cs_n, ras_n, cas_n, we_n, done}, 6'b001110);
        @(posedge clk); #2 rst = 1'b0;
    endtask

    task automatic full_run();
        int lim;
        lim = 0;
        while (!done_seen && lim < 2000) begin @(negedge clk); lim++; end
        chk(done_seen, "R9 init_done reached", int'(done_seen), 1);
        repeat (20) @(negedge clk);
        chk(cke_cyc == STAB, "R1 CKE rise cycle", cke_cyc, STAB);
        chk(cap_cyc[0] == STAB + 1, "R2 first command cycle", cap_cyc[0], STAB + 1);
        chk(cap_n == NEXP, "R3 command count", cap_n, NEXP);
        for (int i = 0; i < NEXP; i++) begin
            chk(cap_cmd[i] == EXP_CMD[i], "R3 command code", int'(cap_cmd[i]), int'(EXP_CMD[i]));
            chk(cap_ba[i] == EXP_BA[i], "R5 bank select", int'(cap_ba[i]), int'(EXP_BA[i]));
            chk(int'(cap_addr[i]) == exp_addr(i), "R4/R5/R6 address opcode",
                int'(cap_addr[i]), exp_addr(i));
            if (i < NEXP - 1)
                chk(cap_cyc[i+1] - cap_cyc[i] == EXP_GAP[i], "R7 command spacing",
                    cap_cyc[i+1] - cap_cyc[i], EXP_GAP[i]);
        end
        chk(nop_bad == 0, "R8 idle bus zero", nop_bad, 0);
        chk(done_cyc == cap_cyc[2] + ((DLL > SPAN) ? DLL : SPAN) + 1, "R9 DLL lock wait",
            done_cyc, cap_cyc[2] + ((DLL > SPAN) ? DLL : SPAN) + 1);
        chk(sticky_bad == 0 && done, "R10 done sticky", sticky_bad, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        // Run A: full-drive, sequential burst.
        do_reset("R1 reset state");
        full_run();

        // Abort mid-sequence, then restart with a different configuration (R11).
        bl = 3'b011; cl = 3'b010; bt = 1'b1; hd = 1'b1;
        do_reset("R11 prepare");
        begin
            int lim = 0;
            while (cap_n < 3 && lim < 500) begin @(negedge clk); lim++; end
        end
        chk(cap_n >= 3 && !done, "R11 mid-sequence point", cap_n, 3);
        do_reset("R11 reset mid-sequence");
        full_run();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule